// File: doc/BRIEF.md
# Multiply/Divide Unit

This block is an arithmetic peripheral on a byte-wide register bus. Software loads two 16-bit operands as four bytes into a 32-bit operand register A. When the fourth of those bytes is written, the unit multiplies the low half of A by the high half. The product is unsigned or signed, as the control register selects. The product goes to the 32-bit result register B. In the accumulate modes it is also added into the 32-bit register C.

A write to the control register with both its divide bit and its go bit set starts an unsigned 32-by-32 division of A by B. The division takes a fixed number of cycles. When it finishes, the quotient is in A, the remainder is in C, and the go bit reads back as zero. Software polls that bit to see when the division is done. While a division runs, the unit ignores all register writes.

The register map uses a 4-bit byte address. A occupies bytes 0 to 3, B bytes 4 to 7 and C bytes 8 to 11, least significant byte first in each. The control register is at byte 12. Reads are combinational and have no side effects. Addresses 13 to 15 read as zero.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, every byte of A, B, C and the control register reads as 0x00.
- R2: While no division runs, a write stores its byte at the addressed location (A at 0-3, B at 4-7, C at 8-11, control at 12), and a read returns it. Addresses 13-15 read 0x00.
- R3: A multiply fires only when all four bytes of A have been written since the last firing, in any order. The write that completes the set clears the written-byte set. Its results are readable after the second rising edge following that write.
- R4: With control bits {7,6,3} equal to 0x00, B receives the unsigned product of A[15:0] and A[31:16], and C is unchanged.
- R5: With mode 0x08, both halves are sign-extended and B receives the two's-complement 32-bit product.
- R6: Modes 0x40 (unsigned) and 0x48 (signed) write the product to B and also write C + product, modulo 2^32, to C.
- R7: When control bit 7 is set, completing the four A bytes produces no result, but the written-byte set still clears.
- R8: A control write with bit 7 and bit 0 both set starts a division. Control bit 0 reads 1 from the edge of that write until the 17th edge after it, and reads 0 from then on.
- R9: When a division ends, A holds the quotient of A divided by {B}, C holds the remainder, and B is unchanged.
- R10: A divisor of zero gives 0xFFFFFFFF in both A and C.
- R11: While a division runs, writes to A, B, C and the control register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| reg_addr | input | 4 | Byte address for reads and writes |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |

## Verification
A register write takes effect at the edge where it is sampled. A multiply result appears one edge later, because the firing write only arms the product stage. A division result appears 17 edges after the start write. The bench model updates at each rising edge and follows these delays: it applies the write at once, takes a product one edge after the arming edge from the pre-edge operands, and counts sixteen step edges before the finishing edge. After each falling edge, the bench reads all thirteen locations, so every result is compared in the very cycle it becomes due and in every cycle after.

// File: rtl/mdu_pkg.sv
`timescale 1ns/1ps
package mdu_pkg;
    localparam int ADDR_W = 4;

    // byte address of the control register
    localparam logic [ADDR_W-1:0] ADR_CTL = 4'd12;

    // control bit positions
    localparam int CTL_GO  = 0;
    localparam int CTL_SGN = 3;
    localparam int CTL_ACC = 6;
    localparam int CTL_DIV = 7;

    localparam logic [7:0] MODE_FIELD = 8'hC8;

    typedef enum logic [7:0] {
        MD_UMUL = 8'h00,
        MD_SMUL = 8'h08,
        MD_UMAC = 8'h40,
        MD_SMAC = 8'h48
    } mode_e;

    typedef enum logic [1:0] {
        BANK_A   = 2'd0,
        BANK_B   = 2'd1,
        BANK_C   = 2'd2,
        BANK_CTL = 2'd3
    } bank_e;
endpackage

// File: rtl/mdu_multiplier.sv
`timescale 1ns/1ps
module mdu_multiplier #(
    parameter int OPW = 16,
    localparam int W = 2 * OPW
) (
    input  logic [OPW-1:0] op_x,
    input  logic [OPW-1:0] op_y,
    input  logic           signed_en,
    input  logic [W-1:0]   acc_in,
    output logic [W-1:0]   product,
    output logic [W-1:0]   acc_sum
);
    // one extra bit per operand carries either zero or the sign
    logic signed [OPW:0]     ext_x;
    logic signed [OPW:0]     ext_y;
    logic signed [2*OPW+1:0] full;

    always_comb begin
        ext_x   = $signed({signed_en & op_x[OPW-1], op_x});
        ext_y   = $signed({signed_en & op_y[OPW-1], op_y});
        full    = ext_x * ext_y;
        product = full[W-1:0];
        acc_sum = acc_in + product;
    end
endmodule

// File: rtl/mdu_divider.sv
`timescale 1ns/1ps
module mdu_divider #(
    parameter int W          = 32,
    parameter int RADIX_BITS = 2,
    localparam int STEPS     = W / RADIX_BITS,
    localparam int CNT_W     = $clog2(STEPS + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [W:0]       rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvs;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W:0]   r_w;
    logic [W-1:0] q_w;

    assign busy = st_q.busy;
    assign done = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        r_w  = st_q.rem;
        q_w  = st_q.quo;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = CNT_W'(STEPS);
                st_d.rem  = '0;
                st_d.quo  = dividend;
                st_d.dvs  = divisor;
            end
        end else if (st_q.cnt == '0) begin
            st_d.busy = 1'b0;
        end else begin
            // restoring steps, RADIX_BITS quotient bits per clock
            for (int i = 0; i < RADIX_BITS; i++) begin
                r_w = {r_w[W-1:0], q_w[W-1]};
                q_w = {q_w[W-2:0], 1'b0};
                if (r_w >= {1'b0, st_q.dvs}) begin
                    r_w    = r_w - {1'b0, st_q.dvs};
                    q_w[0] = 1'b1;
                end
            end
            st_d.rem = r_w;
            st_d.quo = q_w;
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_comb begin
        if (st_q.dvs == '0) begin
            quotient  = '1;
            remainder = '1;
        end else begin
            quotient  = st_q.quo;
            remainder = st_q.rem[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit
    import mdu_pkg::*;
#(
    parameter int OPW        = 16,
    parameter int RADIX_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    localparam int W      = 2 * OPW;
    localparam int NBYTE  = W / 8;
    localparam int LANE_W = $clog2(NBYTE);

    typedef struct packed {
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        logic [W-1:0]     c;
        logic [7:0]       ctrl;
        logic [NBYTE-1:0] a_mask;
        logic             pend;
    } regs_t;

    regs_t st_d, st_q;

    bank_e             bank;
    logic [LANE_W-1:0] lane;
    logic [NBYTE-1:0]  mask_next;
    mode_e             mode;
    logic              mul_we, acc_we;
    logic [W-1:0]      product, acc_sum;
    logic              div_start, div_busy, div_done;
    logic [W-1:0]      div_q, div_r;
    logic [NBYTE-1:0]  a_mask_q;

    assign bank     = bank_e'(reg_addr[ADDR_W-1:ADDR_W-2]);
    assign lane     = reg_addr[LANE_W-1:0];
    assign a_mask_q = st_q.a_mask;

    // mode decode of the pending multiply
    always_comb begin
        mode   = mode_e'(st_q.ctrl & MODE_FIELD);
        mul_we = 1'b0;
        acc_we = 1'b0;
        unique case (mode)
            MD_UMUL, MD_SMUL: mul_we = 1'b1;
            MD_UMAC, MD_SMAC: begin
                mul_we = 1'b1;
                acc_we = 1'b1;
            end
            default: ;
        endcase
    end

    mdu_multiplier #(.OPW(OPW)) u_mul (
        .op_x      (st_q.a[OPW-1:0]),
        .op_y      (st_q.a[W-1:OPW]),
        .signed_en (st_q.ctrl[CTL_SGN]),
        .acc_in    (st_q.c),
        .product   (product),
        .acc_sum   (acc_sum)
    );

    mdu_divider #(.W(W), .RADIX_BITS(RADIX_BITS)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (div_start),
        .dividend  (st_q.a),
        .divisor   (st_q.b),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (div_q),
        .remainder (div_r)
    );

    // next-state logic
    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        div_start = 1'b0;
        mask_next = st_q.a_mask | (NBYTE'(1) << lane);

        if (reg_wr && !div_busy) begin
            unique case (bank)
                BANK_A: begin
                    st_d.a[8*lane +: 8] = reg_wdata;
                    if (&mask_next) begin
                        st_d.a_mask = '0;
                        st_d.pend   = 1'b1;
                    end else begin
                        st_d.a_mask = mask_next;
                    end
                end
                BANK_B: st_d.b[8*lane +: 8] = reg_wdata;
                BANK_C: st_d.c[8*lane +: 8] = reg_wdata;
                BANK_CTL: begin
                    if (reg_addr == ADR_CTL) begin
                        st_d.ctrl = reg_wdata;
                        div_start = reg_wdata[CTL_DIV] & reg_wdata[CTL_GO];
                    end
                end
            endcase
        end

        // armed multiply takes effect one edge after the arming write
        if (st_q.pend && mul_we) begin
            st_d.b = product;
            if (acc_we) st_d.c = acc_sum;
        end

        if (div_done) begin
            st_d.a            = div_q;
            st_d.c            = div_r;
            st_d.ctrl[CTL_GO] = 1'b0;
        end
    end

    // read path
    always_comb begin
        reg_rdata = 8'h00;
        unique case (bank)
            BANK_A:   reg_rdata = st_q.a[8*lane +: 8];
            BANK_B:   reg_rdata = st_q.b[8*lane +: 8];
            BANK_C:   reg_rdata = st_q.c[8*lane +: 8];
            BANK_CTL: if (reg_addr == ADR_CTL) reg_rdata = st_q.ctrl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/muldiv_unit_chk.sv
`timescale 1ns/1ps
module muldiv_unit_chk
    import mdu_pkg::*;
#(
    parameter int DIV_LAT = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              div_busy,
    input logic [3:0]        a_mask
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (div_busy) busy_cnt <= busy_cnt + 1'b1;
        else               busy_cnt <= '0;
    end

    // R8: a divide-and-go control write starts the divider
    p_div_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !div_busy && reg_addr == ADR_CTL && reg_wdata[CTL_DIV] && reg_wdata[CTL_GO])
        |=> div_busy);

    // R8: the divider runs for exactly the fixed latency
    p_div_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_busy) |-> (busy_cnt == 8'(DIV_LAT)));

    // R8: go bit reads set while the divider runs
    p_go_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && reg_addr == ADR_CTL) |-> reg_rdata[CTL_GO]);

    // R3: the fourth distinct A byte clears the written-byte set
    p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !div_busy && reg_addr[3:2] == 2'b00
         && ((a_mask | (4'b0001 << reg_addr[1:0])) == 4'hF))
        |=> (a_mask == 4'h0));

    // R11: operand writes leave the byte set alone during a division
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |=> $stable(a_mask));
endmodule

bind muldiv_unit muldiv_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .div_busy  (div_busy),
    .a_mask    (a_mask_q)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [7:0]  mb [0:12];
    logic [3:0]  m_mask = '0;
    bit          m_pend = 1'b0;
    int          m_cnt  = -1;
    logic [31:0] m_dvd, m_dvs;

    always #5 clk = ~clk;

    muldiv_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [31:0] get32(input int base);
        return {mb[base+3], mb[base+2], mb[base+1], mb[base]};
    endfunction

    task automatic put32(input int base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) mb[base+i] = v[8*i +: 8];
    endtask

    task automatic model_edge(input logic w, input logic [3:0] a, input logic [7:0] d);
        logic [7:0]  o_ctrl;
        logic [31:0] o_a, o_c, p, q, r;
        bit          o_pend, busy;
        longint      x, y;
        o_ctrl = mb[12];
        o_a    = get32(0);
        o_c    = get32(8);
        o_pend = m_pend;
        busy   = (m_cnt >= 0);
        m_pend = 1'b0;
        if (!busy && w) begin
            if (a == 4'd12) begin
                mb[12] = d;
                if (d[7] && d[0]) begin
                    m_cnt = 16;
                    m_dvd = get32(0);
                    m_dvs = get32(4);
                end
            end else if (a < 4'd12) begin
                mb[a] = d;
                if (a < 4'd4) begin
                    m_mask = m_mask | (4'b0001 << a[1:0]);
                    if (m_mask == 4'hF) begin
                        m_mask = '0;
                        m_pend = 1'b1;
                    end
                end
            end
        end
        if (o_pend && !o_ctrl[7]) begin
            if (o_ctrl[3]) begin
                x = longint'(int'($signed(o_a[15:0])));
                y = longint'(int'($signed(o_a[31:16])));
            end else begin
                x = longint'(o_a[15:0]);
                y = longint'(o_a[31:16]);
            end
            p = 32'(x * y);
            put32(4, p);
            if (o_ctrl[6]) put32(8, o_c + p);
        end
        if (busy) begin
            if (m_cnt == 0) begin
                if (m_dvs == 0) begin
                    q = '1;
                    r = '1;
                end else begin
                    q = m_dvd / m_dvs;
                    r = m_dvd % m_dvs;
                end
                put32(0, q);
                put32(8, r);
                mb[12][0] = 1'b0;
                m_cnt = -1;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic check_byte(input int idx, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: got %02h expected %02h", cur_req, idx, got, exp);
        end
    endtask

    // read every location and compare with the model
    task automatic sweep();
        reg_wr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            reg_addr = 4'(i);
            #0.2;
            check_byte(i, reg_rdata, (i < 13) ? mb[i] : 8'h00);
        end
    endtask

    task automatic cycle(input logic w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        sweep();
        reg_wr    = w;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        model_edge(w, a, d);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cycle(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 4'd0, 8'h00);
    endtask

    task automatic wr32(input logic [3:0] base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(base + 4'(i), v[8*i +: 8]);
    endtask

    task automatic mul_run(input logic [15:0] x, input logic [15:0] y);
        wr(4'd2, y[7:0]);
        wr(4'd0, x[7:0]);
        wr(4'd3, y[15:8]);
        wr(4'd1, x[15:8]);
        idle(2);
    endtask

    initial begin
        for (int i = 0; i < 13; i++) mb[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        idle(1);

        cur_req = "R2";
        wr32(4'd4, 32'hA1B2C3D4);
        wr32(4'd8, 32'h0F1E2D3C);
        wr(4'd12, 8'h00);
        idle(1);

        // R3: three bytes leave B alone, the fourth fires
        cur_req = "R3";
        wr(4'd3, 8'h12);
        wr(4'd0, 8'h34);
        wr(4'd1, 8'h56);
        idle(2);
        wr(4'd2, 8'h78);
        idle(2);

        cur_req = "R4";
        mul_run(16'hFFFF, 16'hFFFF);
        mul_run(16'd1234, 16'd5678);

        cur_req = "R5";
        wr(4'd12, 8'h08);
        mul_run(16'h8000, 16'h7FFF);
        mul_run(16'hFFFF, 16'hFFFF);
        mul_run(16'h0003, 16'hFFFE);

        cur_req = "R6";
        wr32(4'd8, 32'h00010000);
        wr(4'd12, 8'h40);
        mul_run(16'h1000, 16'h0100);
        mul_run(16'hFFFF, 16'hFFFF);
        wr32(4'd8, 32'hFFFFFFFF);
        wr(4'd12, 8'h48);
        mul_run(16'h0001, 16'h0002);
        mul_run(16'hFFFF, 16'h0005);

        // R7: disabled multiply, then one byte must not fire a stale set
        cur_req = "R7";
        wr(4'd12, 8'h80);
        mul_run(16'h1111, 16'h2222);
        wr(4'd12, 8'h00);
        wr(4'd0, 8'h05);
        idle(3);

        // R8/R9/R11: division with writes thrown at it while busy
        cur_req = "R8";
        wr32(4'd0, 32'd100000);
        wr32(4'd4, 32'd7);
        wr(4'd12, 8'h81);
        cur_req = "R11";
        wr(4'd0, 8'hEE);
        wr(4'd5, 8'hEE);
        wr(4'd9, 8'hEE);
        wr(4'd12, 8'h00);
        cur_req = "R8";
        idle(16);
        cur_req = "R9";
        idle(3);
        wr32(4'd0, 32'hFFFFFFFF);
        wr32(4'd4, 32'h00010000);
        wr(4'd12, 8'h81);
        idle(20);
        wr32(4'd0, 32'd5);
        wr32(4'd4, 32'd9);
        wr(4'd12, 8'h81);
        idle(20);

        cur_req = "R10";
        wr32(4'd0, 32'h12345678);
        wr32(4'd4, 32'h00000000);
        wr(4'd12, 8'h81);
        idle(20);

        @(negedge clk);
        sweep();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule